// File: doc/BRIEF.md
# Nonvolatile SRAM Store Controller

This controller sits beside a byte-wide SRAM array that has a nonvolatile shadow copy, and it moves the whole array between the two in bulk. A transfer toward the nonvolatile copy, a store, runs as an erase phase followed by a program phase. A transfer back, a recall, runs as a single phase. Each phase holds a command level toward a behavioural nonvolatile model and waits for that model's one-cycle `nv_done` pulse. While any phase runs, host reads and writes to the array are gated off.

A store can start from three sources. The first is a power-fail comparator flag. The second is the falling edge of a shared open-drain request/busy pin, which the controller also pulls low while a store runs. The third is a software trigger, raised when the host reads six fixed addresses in a set order. A dirty flag records whether any SRAM write has completed since the last transfer. The power-fail and pin triggers are dropped when that flag is clear, but a software store always runs. A pin request starts a grace window: reads continue during it, and a write already under way may finish, but writes that start while the pin is low are suppressed.

The host side uses plain strobes and has no stream handshake. A read or write is granted in the same cycle the strobe is seen, or suppressed outright; it is never stalled.

Top module: `nvs_store_ctrl`

## Requirements
- R1: `sram_rd` follows `host_ce & host_rd` when no transfer phase is active, and it is 0 throughout erase, program and recall.
- R2: `sram_wr` is 0 throughout erase, program and recall, whatever the host strobes do.
- R3: `dirty` is 0 after reset. It becomes 1 on the clock edge that sees a granted write's strobe drop, and it returns to 0 when a program or recall phase ends.
- R4: A pin request or a power-fail flag raised while `dirty` is 0 starts no erase.
- R5: Six matching reads start a store even when `dirty` is 0.
- R6: After the edge that sees `hsb_in` fall in idle, the controller waits GRACE_CYC cycles (default 8), with reads still granted, and then enters erase if `dirty` is 1.
- R7: A write granted before the pin fell keeps `sram_wr` high until its strobe drops, and its completion sets `dirty`. A write whose strobe rises while `hsb_in` is 0 is never granted.
- R8: `hsb_drive_low` is 1 during the erase and program phases and 0 during recall.
- R9: The software trigger needs six reads, each counted on a rising `host_ce & host_rd`, at SEQ_ADDRS entries 0..5 in order (default 15'h0A5C, 15'h35A3, 15'h1E0F, 15'h21F0, 15'h0F3C, 15'h30C3). A read from any other address, or the start of any write, returns the match to entry 0.
- R10: A store asserts `nv_erase` until `nv_done`, then `nv_program` until `nv_done`, then returns to idle.
- R11: A power-fail flag raised with `dirty` set enters erase on the next clock edge, with no grace window.
- R12: Triggers that arrive together are taken in this order: power-fail first, then the pin, then the software sequence, then recall. Any trigger that arrives outside idle is dropped.
- R13: `recall_req` in idle asserts `nv_recall` until `nv_done`, with no dirty condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_ce | input | 1 | Host chip enable |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | ADDR_W | Host address |
| sram_rd | output | 1 | Gated read strobe to the array |
| sram_wr | output | 1 | Gated write strobe to the array |
| hsb_in | input | 1 | Level sensed on the shared request/busy pin |
| hsb_drive_low | output | 1 | Pulls the shared pin low while a store runs |
| pwr_fail | input | 1 | Supply below switch threshold |
| recall_req | input | 1 | Recall trigger |
| nv_done | input | 1 | Phase-complete pulse from the nonvolatile model |
| nv_erase | output | 1 | Erase phase active |
| nv_program | output | 1 | Program phase active |
| nv_recall | output | 1 | Recall phase active |
| dirty | output | 1 | A write has completed since the last transfer |

## Verification
Each store source is driven in both the clean and the dirty state. This separates the triggers that are conditional on `dirty` from the unconditional software path. A pin request is raised while a host write is still in flight, and a new write is then attempted during the grace window. This shows whether the gate treats writes in progress differently from writes that start after the pin falls, and a cycle-exact count of the window tells an early start from a late one. The address sequence is played correctly, with a wrong address inside it, and with a write inside it. A scoreboard of expected transfers catches any store or recall that should not have started.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GRACE,
    ST_ERASE,
    ST_PROG,
    ST_RECALL
  } xfer_state_e;
endpackage

// File: rtl/nvs_seq_detect.sv
module nvs_seq_detect #(
  parameter int ADDR_W = 15,
  parameter int SEQ_LEN = 6,
  parameter logic [SEQ_LEN*ADDR_W-1:0] SEQ_ADDRS = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_start,
  input  logic              wr_start,
  input  logic [ADDR_W-1:0] addr,
  output logic              fire
);
  localparam int STEP_W = $clog2(SEQ_LEN);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(SEQ_LEN - 1);

  logic [STEP_W-1:0] step;
  logic [SEQ_LEN-1:0] hit;

  for (genvar i = 0; i < SEQ_LEN; i++) begin : g_cmp
    assign hit[i] = (addr == SEQ_ADDRS[i*ADDR_W +: ADDR_W]);
  end

  logic match;
  assign match = hit[step];
  assign fire  = rd_start & match & (step == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step <= '0;
    else if (wr_start) step <= '0;
    else if (rd_start) begin
      if (!match || step == LAST) step <= '0;
      else step <= step + 1'b1;
    end
  end

  // R9: the match pointer never leaves the sequence
  a_r9_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
    step <= LAST);
  // R9: a write start always resets the match
  a_r9_write_resets: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |=> step == '0);
endmodule

// File: rtl/nvs_access_gate.sv
module nvs_access_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic host_ce,
  input  logic host_rd,
  input  logic host_wr,
  input  logic pin_high,
  input  logic xfer,
  output logic sram_rd,
  output logic sram_wr,
  output logic rd_start,
  output logic wr_start,
  output logic wr_done
);
  logic rd_prev, wr_prev, wr_live;
  logic rd_act, wr_act, wr_grant;

  assign rd_act   = host_ce & host_rd;
  assign wr_act   = host_ce & host_wr;
  assign rd_start = rd_act & ~rd_prev;
  assign wr_start = wr_act & ~wr_prev;
  // a write keeps its grant once given; a new one needs the pin released
  assign wr_grant = ~xfer & (wr_live | (wr_start & pin_high));
  assign sram_wr  = wr_act & wr_grant;
  assign sram_rd  = rd_act & ~xfer;
  assign wr_done  = wr_live & ~wr_act & ~xfer;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_prev <= 1'b0;
      wr_prev <= 1'b0;
      wr_live <= 1'b0;
    end else begin
      rd_prev <= rd_act;
      wr_prev <= wr_act;
      wr_live <= xfer ? 1'b0 : (wr_act & wr_grant);
    end
  end

  // R7: a write cannot be granted anew while the pin is held low
  a_r7_no_new_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_start && !pin_high) |-> !sram_wr);
endmodule

// File: rtl/nvs_xfer_fsm.sv
module nvs_xfer_fsm
  import nvs_pkg::*;
#(
  parameter int GRACE_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_fail,
  input  logic hw_fall,
  input  logic sw_fire,
  input  logic recall_req,
  input  logic wr_done,
  input  logic nv_done,
  output logic nv_erase,
  output logic nv_program,
  output logic nv_recall,
  output logic xfer,
  output logic busy_low,
  output logic dirty
);
  localparam int CNT_W = $clog2(GRACE_CYC + 1);
  localparam logic [CNT_W-1:0] GRACE_LAST = CNT_W'(GRACE_CYC - 1);

  xfer_state_e state, nxt;
  logic [CNT_W-1:0] gcnt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: begin
        if (pwr_fail && dirty) nxt = ST_ERASE;
        else if (hw_fall)      nxt = ST_GRACE;
        else if (sw_fire)      nxt = ST_ERASE;
        else if (recall_req)   nxt = ST_RECALL;
      end
      ST_GRACE:  if (gcnt == GRACE_LAST) nxt = dirty ? ST_ERASE : ST_IDLE;
      ST_ERASE:  if (nv_done) nxt = ST_PROG;
      ST_PROG:   if (nv_done) nxt = ST_IDLE;
      ST_RECALL: if (nv_done) nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      gcnt  <= '0;
      dirty <= 1'b0;
    end else begin
      state <= nxt;
      gcnt  <= (state == ST_GRACE) ? gcnt + 1'b1 : '0;
      if ((state == ST_PROG || state == ST_RECALL) && nv_done) dirty <= 1'b0;
      else if (wr_done) dirty <= 1'b1;
    end
  end

  assign nv_erase   = (state == ST_ERASE);
  assign nv_program = (state == ST_PROG);
  assign nv_recall  = (state == ST_RECALL);
  assign xfer       = nv_erase | nv_program | nv_recall;
  assign busy_low   = nv_erase | nv_program;

  // R10: program is only ever entered from erase
  a_r10_prog_after_erase: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nv_program) |-> $past(nv_erase));
  // R3: finishing a transfer leaves the flag clear
  a_r3_clear_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(nv_program) || $fell(nv_recall)) |-> !dirty);
  // R11: a power-fail flag with dirty data in idle skips the grace window
  a_r11_pf_direct: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && pwr_fail && dirty) |=> nv_erase);
endmodule

// File: rtl/nvs_store_ctrl.sv
module nvs_store_ctrl #(
  parameter int ADDR_W = 15,
  parameter int SEQ_LEN = 6,
  parameter int GRACE_CYC = 8,
  parameter logic [SEQ_LEN*ADDR_W-1:0] SEQ_ADDRS = {
    15'h30C3, 15'h0F3C, 15'h21F0, 15'h1E0F, 15'h35A3, 15'h0A5C}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_ce,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  output logic              sram_rd,
  output logic              sram_wr,
  input  logic              hsb_in,
  output logic              hsb_drive_low,
  input  logic              pwr_fail,
  input  logic              recall_req,
  input  logic              nv_done,
  output logic              nv_erase,
  output logic              nv_program,
  output logic              nv_recall,
  output logic              dirty
);
  logic hsb_prev, hw_fall, xfer, busy_low;
  logic rd_start, wr_start, wr_done, sw_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hsb_prev <= 1'b1;
    else        hsb_prev <= hsb_in;
  end
  assign hw_fall = hsb_prev & ~hsb_in;

  nvs_access_gate u_gate (
    .clk(clk), .rst_n(rst_n), .host_ce(host_ce), .host_rd(host_rd),
    .host_wr(host_wr), .pin_high(hsb_in), .xfer(xfer),
    .sram_rd(sram_rd), .sram_wr(sram_wr), .rd_start(rd_start),
    .wr_start(wr_start), .wr_done(wr_done)
  );

  nvs_seq_detect #(.ADDR_W(ADDR_W), .SEQ_LEN(SEQ_LEN), .SEQ_ADDRS(SEQ_ADDRS)) u_seq (
    .clk(clk), .rst_n(rst_n), .rd_start(rd_start & ~xfer),
    .wr_start(wr_start), .addr(host_addr), .fire(sw_fire)
  );

  nvs_xfer_fsm #(.GRACE_CYC(GRACE_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail), .hw_fall(hw_fall),
    .sw_fire(sw_fire), .recall_req(recall_req), .wr_done(wr_done),
    .nv_done(nv_done), .nv_erase(nv_erase), .nv_program(nv_program),
    .nv_recall(nv_recall), .xfer(xfer), .busy_low(busy_low), .dirty(dirty)
  );

  assign hsb_drive_low = busy_low;

  // R1: reads are cut during every transfer phase
  a_r1_rd_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_erase || nv_program || nv_recall) |-> !sram_rd);
  // R2: writes are cut during every transfer phase
  a_r2_wr_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_erase || nv_program || nv_recall) |-> !sram_wr);
  // R8: busy pin is pulled during store phases only
  a_r8_busy_store: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_erase || nv_program) |-> hsb_drive_low);
  // R8: recall leaves the pin released
  a_r8_recall_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
    nv_recall |-> !hsb_drive_low);
endmodule

// File: tb/tb_nvs_store_ctrl.sv
`timescale 1ns/1ps
module tb_nvs_store_ctrl;
  localparam int AW = 15;
  localparam int G  = 8;
  localparam logic [AW-1:0] SEQ [6] = '{15'h0A5C, 15'h35A3, 15'h1E0F,
                                        15'h21F0, 15'h0F3C, 15'h30C3};
  localparam logic [7:0] K_STORE = 8'h53, K_RECALL = 8'h52;

  logic clk = 0, rst_n = 0;
  logic host_ce = 0, host_rd = 0, host_wr = 0;
  logic [AW-1:0] host_addr = '0;
  logic sram_rd, sram_wr, hsb_drive_low, hsb_in;
  logic pwr_fail = 0, recall_req = 0, nv_done = 0, ext_low = 0;
  logic nv_erase, nv_program, nv_recall, dirty;
  int compared = 0, mismatched = 0;
  logic [7:0] expq[$];

  always #2 clk = ~clk;
  assign hsb_in = ~(ext_low | hsb_drive_low);

  nvs_store_ctrl dut (
    .clk(clk), .rst_n(rst_n), .host_ce(host_ce), .host_rd(host_rd),
    .host_wr(host_wr), .host_addr(host_addr), .sram_rd(sram_rd),
    .sram_wr(sram_wr), .hsb_in(hsb_in), .hsb_drive_low(hsb_drive_low),
    .pwr_fail(pwr_fail), .recall_req(recall_req), .nv_done(nv_done),
    .nv_erase(nv_erase), .nv_program(nv_program), .nv_recall(nv_recall),
    .dirty(dirty)
  );

  // behavioural nonvolatile model: done three cycles into each phase
  logic [1:0] nvcnt = 0;
  always @(posedge clk) begin
    if (nv_done) begin nv_done <= 0; nvcnt <= 0; end
    else if (nv_erase | nv_program | nv_recall) begin
      if (nvcnt == 2) nv_done <= 1; else nvcnt <= nvcnt + 1;
    end else nvcnt <= 0;
  end

  // monitor: each finished transfer pops the scoreboard
  logic prog_q = 0, rec_q = 0;
  always @(negedge clk) begin
    if (prog_q && !nv_program) pop_cmp(K_STORE);
    if (rec_q && !nv_recall)   pop_cmp(K_RECALL);
    prog_q <= nv_program;
    rec_q  <= nv_recall;
  end

  task automatic pop_cmp(input logic [7:0] got);
    compared++;
    if (expq.size() == 0) begin
      mismatched++;
      $display("FAIL R12 unexpected transfer: actual=%0h expected=none", got);
    end else begin
      logic [7:0] e = expq.pop_front();
      if (e != got) begin
        mismatched++;
        $display("FAIL R10 transfer kind: actual=%0h expected=%0h", got, e);
      end
    end
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic do_read(input logic [AW-1:0] a);
    host_ce = 1; host_rd = 1; host_addr = a; tick();
    host_ce = 0; host_rd = 0; tick();
  endtask

  task automatic do_write(input logic [AW-1:0] a);
    host_ce = 1; host_wr = 1; host_addr = a; tick(); tick();
    host_ce = 0; host_wr = 0; tick(); tick();
  endtask

  task automatic wait_quiet();
    int n = 0;
    tick();
    while ((nv_erase | nv_program | nv_recall) && n < 200) begin tick(); n++; end
    tick();
  endtask

  initial begin
    #(4 * 150000);
    mismatched++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1; tick();
    // reset state (R3)
    check("R3 reset dirty", dirty, 0);
    check("R8 reset busy", hsb_drive_low, 0);
    check("R10 reset erase", nv_erase, 0);

    // R1 read passes in idle
    host_ce = 1; host_rd = 1; host_addr = 15'h0100; #1;
    check("R1 idle read", sram_rd, 1);
    tick(); host_ce = 0; host_rd = 0; tick();

    // R3 write completion sets dirty
    host_ce = 1; host_wr = 1; host_addr = 15'h0200; #1;
    check("R7 idle write grant", sram_wr, 1);
    tick(); tick(); host_ce = 0; host_wr = 0; tick(); tick();
    check("R3 dirty after write", dirty, 1);

    // R11 power-fail with dirty data: erase next edge
    expq.push_back(K_STORE);
    pwr_fail = 1; tick();
    check("R11 pf erase", nv_erase, 1);
    check("R8 busy in erase", hsb_drive_low, 1);
    host_ce = 1; host_rd = 1; #1;
    check("R1 read blocked", sram_rd, 0);
    host_rd = 0; host_wr = 1; host_addr = 15'h0300; #1;
    check("R2 write blocked", sram_wr, 0);
    tick(); host_ce = 0; host_wr = 0;
    while (!nv_program) tick();
    check("R10 erase ended before program", nv_erase, 0);
    wait_quiet();
    check("R3 dirty cleared by store", dirty, 0);

    // R4 power-fail while clean: nothing
    repeat (12) tick();
    check("R4 pf clean no erase", nv_erase, 0);
    pwr_fail = 0; tick();

    // R4 pin request while clean; R7 new write suppressed
    ext_low = 1;
    repeat (G + 4) tick();
    check("R4 pin clean no erase", nv_erase, 0);
    host_ce = 1; host_wr = 1; host_addr = 15'h0400; #1;
    check("R7 write while pin low", sram_wr, 0);
    tick(); host_ce = 0; host_wr = 0; tick(); tick();
    check("R4 dirty stays clear", dirty, 0);
    ext_low = 0; tick(); tick();

    // R6/R7 grace window with write in flight
    host_ce = 1; host_wr = 1; host_addr = 15'h0500; #1;  // n0
    check("R7 write starts", sram_wr, 1);
    tick(); ext_low = 1;                                  // n1
    tick(); #1;                                           // n2
    check("R7 in-flight write continues", sram_wr, 1);
    tick(); host_ce = 0; host_wr = 0;                     // n3
    tick();                                               // n4
    check("R7 in-flight write sets dirty", dirty, 1);
    expq.push_back(K_STORE);
    tick(); host_ce = 1; host_wr = 1; host_addr = 15'h0600; #1;  // n5
    check("R7 new write in grace", sram_wr, 0);
    tick(); host_wr = 0; host_ce = 0;                     // n6
    tick(); host_ce = 1; host_rd = 1; host_addr = 15'h0700; #1;  // n7
    check("R6 read in grace", sram_rd, 1);
    tick(); host_ce = 0; host_rd = 0;                     // n8
    tick();                                               // n9
    check("R6 still in grace", nv_erase, 0);
    tick();                                               // n10
    check("R6 erase after grace", nv_erase, 1);
    check("R8 busy pin pulled", hsb_drive_low, 1);
    wait_quiet();
    ext_low = 0; tick(); tick();

    // R5 software sequence while clean
    check("R5 clean before seq", dirty, 0);
    expq.push_back(K_STORE);
    for (int i = 0; i < 6; i++) do_read(SEQ[i]);
    check("R5 seq store started", nv_erase | nv_program, 1);
    wait_quiet();

    // R9 wrong address inside sequence
    for (int i = 0; i < 3; i++) do_read(SEQ[i]);
    do_read(15'h0123);
    for (int i = 3; i < 6; i++) do_read(SEQ[i]);
    tick();
    check("R9 wrong addr no store", nv_erase, 0);

    // R9 write inside sequence
    for (int i = 0; i < 3; i++) do_read(SEQ[i]);
    do_write(15'h0800);
    for (int i = 3; i < 6; i++) do_read(SEQ[i]);
    tick();
    check("R9 write resets seq", nv_erase, 0);
    check("R3 dirty from seq write", dirty, 1);

    // R13 recall clears dirty, no busy
    expq.push_back(K_RECALL);
    recall_req = 1; tick(); recall_req = 0;
    check("R13 recall active", nv_recall, 1);
    check("R8 recall leaves pin", hsb_drive_low, 0);
    wait_quiet();
    check("R3 dirty cleared by recall", dirty, 0);

    // R12 priority: power-fail beats the pin; busy ignores recall
    do_write(15'h0900);
    expq.push_back(K_STORE);
    pwr_fail = 1; ext_low = 1; tick();
    check("R12 pf over pin", nv_erase, 1);
    recall_req = 1; tick(); recall_req = 0;
    wait_quiet();
    pwr_fail = 0; ext_low = 0;
    repeat (10) tick();
    check("R12 recall during busy ignored", nv_recall, 0);

    compared++;
    if (expq.size() != 0) begin
      mismatched++;
      $display("FAIL R10 missing transfers: actual=%0d expected=0", expq.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule